// File: doc/BRIEF.md
# Escaped Packet Deframer with CRC and Sequence Check

This block sits behind a UART receiver and takes its bytes one at a time over a valid/ready handshake. It looks for packets that a 0xFF flag byte opens and a separate 0xFF flag byte closes. It removes the 0xCB escape coding from the bytes between the flags. It then splits the decoded bytes into a sequence number, a payload, an acknowledgement number and a 16-bit CRC trailer.

Payload bytes are held in an internal buffer until the packet has closed and has passed both the CRC check and the sequence check. Only then are they released on an output stream. The most recent valid acknowledgement number and the next expected sequence number are shown as steady outputs for a transmit-side controller. A packet that fails either check leaves no trace at the ports. A malformed packet is also discarded.

Top module: `pkt_deframer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, ack_valid is 0 and exp_seq is 0.
- R2: In the idle state every byte other than 0xFF is ignored. An 0xFF opens a packet, and the next unescaped 0xFF closes it. A closing 0xFF is never taken as the opening flag of the following packet.
- R3: Inside a packet, the pair 0xCB 0x34 decodes to 0xFF and the pair 0xCB 0x00 decodes to 0xCB. Every other byte stands for itself.
- R4: A packet is accepted only if its last two decoded bytes equal a CRC computed over all earlier decoded bytes. The CRC is the polynomial 0x1021 with start value 0xFFFF, no bit reflection and no final XOR, sent high byte first. On a mismatch the packet changes no output.
- R5: In a decoded packet of n >= 4 bytes, byte 0 is the sequence number, bytes 1 to n-4 are payload, byte n-3 is the acknowledgement number and bytes n-2 and n-1 are the CRC. An accepted packet sends out its payload in arrival order.
- R6: A decoded packet of exactly 3 bytes is acknowledgement only. When its CRC is good, ack_num takes byte 0 and ack_valid becomes 1 and stays 1. exp_seq does not change and no payload is sent.
- R7: A packet of 4 or more bytes whose sequence byte differs from exp_seq is dropped entirely. Neither ack_num nor exp_seq changes, and no payload is sent.
- R8: When a packet of 4 or more bytes is accepted, ack_num takes its acknowledgement byte and exp_seq increments modulo 256, both on the clock edge that takes in the closing flag. out_valid stays 0 while a packet is still being received.
- R9: A packet is discarded if it decodes to fewer than 3 bytes or carries more than DEPTH payload bytes. After an 0xCB followed by a byte other than 0x34 or 0x00, the block ignores input up to and including the packet's closing 0xFF. In all these cases the next packet is received normally.
- R10: While out_valid is 1, in_ready is 0. While out_valid is 1 and out_ready is 0, out_data holds its value.
- R11: An accepted packet of exactly 4 decoded bytes (no payload) increments exp_seq and sends no payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received byte is present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Block accepts a byte; 0 while payload is being released |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Consumer takes the payload byte |
| ack_valid | output | 1 | At least one valid acknowledgement has been received |
| ack_num | output | 8 | Most recent valid acknowledgement number |
| exp_seq | output | 8 | Next expected sequence number |

## Verification
A decoder stuck in the escape or skip state shows up at the ports one packet later: the next good packet is not accepted, so exp_seq fails to advance on the edge that takes in its closing flag. A shift window that is off by one byte feeds the wrong bytes to the CRC. Every good packet is then dropped, and the first one does not update ack_num. A wrong payload pointer appears as a wrong, missing or extra byte in the first released payload. Because exp_seq, ack_num and the output stream are compared against a behavioural model on every clock, most faults are seen within one packet.

// File: rtl/pkt_deframe_pkg.sv
package pkt_deframe_pkg;

  localparam logic [7:0] FLAG_BYTE = 8'hFF;
  localparam logic [7:0] ESC_BYTE  = 8'hCB;
  localparam logic [7:0] ESC_OF_FLAG = 8'h34;
  localparam logic [7:0] ESC_OF_ESC  = 8'h00;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_BODY = 2'd1,
    DEC_ESC  = 2'd2,
    DEC_SKIP = 2'd3
  } dec_state_t;

  // one byte of the CRC, high bit first
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      if (c[15]) c = (c << 1) ^ CRC_POLY;
      else       c = c << 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/esc_decoder.sv
module esc_decoder
  import pkt_deframe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] din,
  output logic       ev_open,
  output logic       ev_byte,
  output logic       ev_close,
  output logic       ev_bad,
  output logic [7:0] byte_out
);

  dec_state_t st, st_nxt;

  always_comb begin
    st_nxt   = st;
    ev_open  = 1'b0;
    ev_byte  = 1'b0;
    ev_close = 1'b0;
    ev_bad   = 1'b0;
    byte_out = din;
    if (fire) begin
      case (st)
        DEC_IDLE: begin
          if (din == FLAG_BYTE) begin
            ev_open = 1'b1;
            st_nxt  = DEC_BODY;
          end
        end
        DEC_BODY: begin
          if (din == FLAG_BYTE) begin
            ev_close = 1'b1;
            st_nxt   = DEC_IDLE;
          end else if (din == ESC_BYTE) begin
            st_nxt = DEC_ESC;
          end else begin
            ev_byte = 1'b1;
          end
        end
        DEC_ESC: begin
          if (din == ESC_OF_FLAG || din == ESC_OF_ESC) begin
            ev_byte  = 1'b1;
            byte_out = din ^ ESC_BYTE;
            st_nxt   = DEC_BODY;
          end else if (din == FLAG_BYTE) begin
            ev_bad = 1'b1;
            st_nxt = DEC_IDLE;
          end else begin
            ev_bad = 1'b1;
            st_nxt = DEC_SKIP;
          end
        end
        default: begin
          if (din == FLAG_BYTE) st_nxt = DEC_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= DEC_IDLE;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/payload_buffer.sv
module payload_buffer #(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       start,
  input  logic       out_ready,
  output logic       full,
  output logic       busy,
  output logic [7:0] out_data
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = AW + 1;

  logic [7:0]       mem [DEPTH];
  logic [LVL_W-1:0] wr_ptr;
  logic [LVL_W-1:0] rd_ptr;
  logic             last_rd;

  assign full     = (wr_ptr == LVL_W'(DEPTH));
  assign out_data = mem[rd_ptr[AW-1:0]];
  assign last_rd  = ((rd_ptr + LVL_W'(1)) == wr_ptr);

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      busy   <= 1'b0;
    end else begin
      if (clr)                wr_ptr <= '0;
      else if (push && !full) wr_ptr <= wr_ptr + LVL_W'(1);
      if (start && wr_ptr != '0) begin
        busy   <= 1'b1;
        rd_ptr <= '0;
      end else if (busy && out_ready) begin
        rd_ptr <= rd_ptr + LVL_W'(1);
        if (last_rd) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframe_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       ack_valid,
  output logic [7:0] ack_num,
  output logic [7:0] exp_seq
);

  localparam logic [2:0] CNT_SEQ  = 3'd3;  // three bytes held: next arrival commits the sequence byte
  localparam logic [2:0] CNT_DATA = 3'd4;  // saturated: four or more bytes seen

  // named internal events, observed by the checker
  logic       fire;
  logic       ev_open, ev_byte, ev_close, ev_bad;
  logic [7:0] dec_byte;
  logic       commit, commit_seq, commit_data;
  logic       buf_full, busy, buf_push, overflow;
  logic       frame_ok, ack_only, data_ok, pkt_accept;
  logic [15:0] crc_final;

  logic [2:0]  cnt;
  logic [7:0]  win0, win1, win2;
  logic [15:0] crc_r;
  logic [7:0]  seq_r;
  logic        spoil;
  logic        ack_v_r;
  logic [7:0]  ack_r, exp_r;

  assign in_ready = !busy;
  assign fire     = in_valid && in_ready;

  esc_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .din      (in_data),
    .ev_open  (ev_open),
    .ev_byte  (ev_byte),
    .ev_close (ev_close),
    .ev_bad   (ev_bad),
    .byte_out (dec_byte)
  );

  assign commit      = ev_byte && (cnt >= CNT_SEQ);
  assign commit_seq  = commit && (cnt == CNT_SEQ);
  assign commit_data = commit && (cnt == CNT_DATA);
  assign buf_push    = commit_data && !buf_full;
  assign overflow    = commit_data && buf_full;

  assign crc_final  = crc16_step(crc_r, win0);
  assign frame_ok   = ev_close && (cnt >= CNT_SEQ) && !spoil && (crc_final == {win1, win2});
  assign ack_only   = frame_ok && (cnt == CNT_SEQ);
  assign data_ok    = frame_ok && (cnt == CNT_DATA) && (seq_r == exp_r);
  assign pkt_accept = ack_only || data_ok;

  payload_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_open),
    .push      (buf_push),
    .push_data (win0),
    .start     (data_ok),
    .out_ready (out_ready),
    .full      (buf_full),
    .busy      (busy),
    .out_data  (out_data)
  );

  assign out_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      win0  <= '0;
      win1  <= '0;
      win2  <= '0;
      crc_r <= CRC_SEED;
      seq_r <= '0;
      spoil <= 1'b0;
    end else if (ev_open) begin
      cnt   <= '0;
      crc_r <= CRC_SEED;
      spoil <= 1'b0;
    end else if (ev_byte) begin
      win0 <= win1;
      win1 <= win2;
      win2 <= dec_byte;
      if (cnt != CNT_DATA) cnt <= cnt + 3'd1;
      if (commit)          crc_r <= crc16_step(crc_r, win0);
      if (commit_seq)      seq_r <= win0;
      if (overflow)        spoil <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_v_r <= 1'b0;
      ack_r   <= '0;
      exp_r   <= '0;
    end else begin
      if (pkt_accept) begin
        ack_v_r <= 1'b1;
        ack_r   <= win0;
      end
      if (data_ok) exp_r <= exp_r + 8'd1;
    end
  end

  assign ack_valid = ack_v_r;
  assign ack_num   = ack_r;
  assign exp_seq   = exp_r;

endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       ack_valid,
  input logic [7:0] exp_seq,
  input logic       ev_open,
  input logic       ev_byte,
  input logic       ev_close,
  input logic       ev_bad,
  input logic       data_ok,
  input logic       ack_only
);

  p_events_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_open, ev_byte, ev_close, ev_bad}));

  p_no_input_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok |=> (exp_seq == $past(exp_seq) + 8'd1));

  p_seq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ok |=> $stable(exp_seq));

  p_ack_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_valid);

  p_ackonly_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_only |=> (ack_valid && !out_valid));

  p_release_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(data_ok));

endmodule

bind pkt_deframer pkt_deframer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .ack_valid (ack_valid),
  .exp_seq   (exp_seq),
  .ev_open   (ev_open),
  .ev_byte   (ev_byte),
  .ev_close  (ev_close),
  .ev_bad    (ev_bad),
  .data_ok   (data_ok),
  .ack_only  (ack_only)
);

// File: tb/pkt_deframer_tb_top.sv
module pkt_deframer_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready;
  logic       ack_valid;
  logic [7:0] ack_num;
  logic [7:0] exp_seq;

  always #4 clk = ~clk;

  pkt_deframer #(.DEPTH(DEPTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .exp_seq   (exp_seq)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_st = 0;        // 0 idle, 1 body, 2 escape, 3 skip
  logic [7:0] m_q[$];
  logic [7:0] exp_out[$];
  logic [7:0] m_exp_seq = 8'd0;
  logic [7:0] m_ack = 8'd0;
  bit         m_ackv = 1'b0;
  bit         run_cmp = 1'b0;
  bit         slow_rd = 1'b0;

  function automatic int ref_crc(input int upto);
    int c = 16'hFFFF;
    for (int j = 0; j < upto; j++) begin
      for (int i = 7; i >= 0; i--) begin
        int fb;
        fb = ((c >> 15) ^ (int'(m_q[j]) >> i)) & 1;
        c = (c << 1) & 16'hFFFF;
        if (fb != 0) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic model_close();
    int n = m_q.size();
    if (n < 3) return;
    if (n - 4 > DEPTH) return;
    if (ref_crc(n - 2) != {m_q[n-2], m_q[n-1]}) return;
    if (n == 3) begin
      m_ack = m_q[0]; m_ackv = 1'b1;
    end else if (m_q[0] == m_exp_seq) begin
      m_ack = m_q[n-3]; m_ackv = 1'b1;
      m_exp_seq = m_exp_seq + 8'd1;
      for (int k = 1; k <= n - 4; k++) exp_out.push_back(m_q[k]);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_st)
      0: if (b == 8'hFF) begin m_st = 1; m_q.delete(); end
      1: begin
        if (b == 8'hFF) begin model_close(); m_st = 0; end
        else if (b == 8'hCB) m_st = 2;
        else m_q.push_back(b);
      end
      2: begin
        if (b == 8'h34) begin m_q.push_back(8'hFF); m_st = 1; end
        else if (b == 8'h00) begin m_q.push_back(8'hCB); m_st = 1; end
        else if (b == 8'hFF) m_st = 0;
        else m_st = 3;
      end
      default: if (b == 8'hFF) m_st = 0;
    endcase
  endtask

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (run_cmp) begin
      check(exp_seq == m_exp_seq, "R8 exp_seq", exp_seq, m_exp_seq);
      check(ack_valid == m_ackv, "R6 ack_valid", ack_valid, m_ackv);
      if (m_ackv) check(ack_num == m_ack, "R6 ack_num", ack_num, m_ack);
      if (m_st == 1 || m_st == 2) check(!out_valid, "R8 payload held during receive", out_valid, 0);
      if (out_valid) check(!in_ready, "R10 input blocked while releasing", in_ready, 0);
    end
  end

  // output stream monitor
  logic [7:0] hold_data;
  bit         hold_pend = 1'b0;
  always @(negedge clk) begin
    if (run_cmp) begin
      if (hold_pend && out_valid) check(out_data == hold_data, "R10 out_data stable", out_data, hold_data);
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_out.size() == 0) check(1'b0, "R5 unexpected payload byte", out_data, -1);
        else begin
          logic [7:0] e;
          e = exp_out.pop_front();
          check(out_data == e, "R5 payload byte", out_data, e);
        end
      end
    end
  end

  logic [7:0] lfsr = 8'h5B;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = slow_rd ? (lfsr[1:0] == 2'b00) : (lfsr[0] | lfsr[2]);
  end

  // ---------------- drivers ----------------
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    model_byte(b);
    @(posedge clk);
  endtask

  task automatic send_esc(input logic [7:0] b);
    if (b == 8'hFF) begin send_byte(8'hCB); send_byte(8'h34); end
    else if (b == 8'hCB) begin send_byte(8'hCB); send_byte(8'h00); end
    else send_byte(b);
  endtask

  logic [7:0] body[$];

  task automatic send_pkt(input bit bad_crc);
    int c = 16'hFFFF;
    for (int j = 0; j < body.size(); j++)
      for (int i = 7; i >= 0; i--) begin
        int fb;
        fb = ((c >> 15) ^ (int'(body[j]) >> i)) & 1;
        c = (c << 1) & 16'hFFFF;
        if (fb != 0) c = c ^ 16'h1021;
      end
    if (bad_crc) c = c ^ 1;
    send_byte(8'hFF);
    foreach (body[j]) send_esc(body[j]);
    send_esc(8'(c >> 8));
    send_esc(8'(c));
    send_byte(8'hFF);
  endtask

  task automatic make_data(input logic [7:0] seq, input int n, input int seed, input logic [7:0] ack);
    body.delete();
    body.push_back(seq);
    for (int i = 0; i < n; i++) body.push_back(8'((seed + i * 37) & 8'hFF));
    body.push_back(ack);
  endtask

  task automatic settle(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready || exp_out.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_out.size() == 0 && !out_valid, req, exp_out.size(), 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog expired", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(ack_valid == 1'b0, "R1 ack_valid after reset", ack_valid, 0);
    check(exp_seq == 8'd0, "R1 exp_seq after reset", exp_seq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1'b1;

    // R6: acknowledgement-only packet
    body = '{8'h5A};
    send_pkt(1'b0);
    settle("R6 ack-only quiet");
    check(ack_num == 8'h5A && ack_valid, "R6 ack-only value", ack_num, 8'h5A);

    // R3, R5: escaped payload bytes
    body = '{8'h00, 8'hFF, 8'hCB, 8'h34, 8'h00, 8'h11, 8'h07};
    send_pkt(1'b0);
    settle("R3 escaped payload drained");
    check(exp_seq == 8'd1, "R5 seq advanced", exp_seq, 1);

    // R4: bad CRC dropped
    make_data(8'd1, 5, 3, 8'h44);
    send_pkt(1'b1);
    settle("R4 bad CRC no payload");
    check(ack_num == 8'h07 && exp_seq == 8'd1, "R4 bad CRC no state change", ack_num, 8'h07);

    // R7: wrong sequence dropped
    make_data(8'd5, 4, 9, 8'h99);
    send_pkt(1'b0);
    settle("R7 wrong seq no payload");
    check(ack_num == 8'h07 && exp_seq == 8'd1, "R7 wrong seq ignored", ack_num, 8'h07);

    // R2: noise between packets, then back-to-back packets
    send_byte(8'h12); send_byte(8'hCB); send_byte(8'h34);
    make_data(8'd1, 3, 20, 8'h21);
    send_pkt(1'b0);
    make_data(8'd2, 2, 50, 8'h22);
    send_pkt(1'b0);
    settle("R2 framing");
    check(exp_seq == 8'd3 && ack_num == 8'h22, "R2 back-to-back accepted", exp_seq, 3);

    // R9: too short; R11: empty data packet
    send_byte(8'hFF); send_byte(8'h01); send_byte(8'h02); send_byte(8'hFF);
    settle("R9 short packet");
    check(exp_seq == 8'd3, "R9 short packet ignored", exp_seq, 3);
    make_data(8'd3, 0, 0, 8'h33);
    send_pkt(1'b0);
    settle("R11 empty payload");
    check(exp_seq == 8'd4, "R11 empty packet advances seq", exp_seq, 4);

    // R9: bad escape skips to close, next packet received
    send_byte(8'hFF); send_byte(8'h04); send_byte(8'hCB); send_byte(8'h55);
    send_byte(8'h11); send_byte(8'hFF);
    make_data(8'd4, 3, 77, 8'h44);
    send_pkt(1'b0);
    settle("R9 bad escape recovery");
    check(exp_seq == 8'd5, "R9 packet after bad escape", exp_seq, 5);

    // R9 boundary and R10 back-pressure
    slow_rd = 1'b1;
    make_data(8'd5, DEPTH, 1, 8'h55);
    send_pkt(1'b0);
    settle("R10 full buffer drained slowly");
    check(exp_seq == 8'd6, "R9 exactly DEPTH accepted", exp_seq, 6);
    make_data(8'd6, DEPTH + 1, 2, 8'h66);
    send_pkt(1'b0);
    settle("R9 overflow no payload");
    check(exp_seq == 8'd6, "R9 DEPTH+1 discarded", exp_seq, 6);
    slow_rd = 1'b0;

    // R8: modulo-256 wrap of the expected sequence
    while (m_exp_seq != 8'd0) begin
      make_data(m_exp_seq, 0, 0, 8'hA5);
      send_pkt(1'b0);
    end
    settle("R8 wrap");
    check(exp_seq == 8'd0, "R8 exp_seq wraps to 0", exp_seq, 0);
    make_data(8'd0, 2, 9, 8'h01);
    send_pkt(1'b0);
    settle("R8 after wrap");
    check(exp_seq == 8'd1, "R8 seq 0 accepted after wrap", exp_seq, 1);

    run_cmp = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule